// File: doc/BRIEF.md
# Two-Wire Keyboard Link: Device-Side Host Frame Receiver

This block sits on the peripheral end of a PS/2 link and takes in bytes that the host sends. It watches the shared open-drain CLK and DATA lines. It recognises the host's request to send: CLK is held low for a long stretch and then let go while DATA is already low. The block then becomes the clock master. It releases and pulls CLK to make eleven pulses, and it samples DATA while CLK is released. After the stop bit, it acknowledges a clean frame by pulling DATA low through the last pulse.

The block never drives a line high. It only outputs pull-down enables, and the pad ring turns these into open-drain drivers. A transmit path elsewhere on the device shares the lines. That path reports whether it is busy, whether it has passed its tenth clock, and when it is pulling CLK itself. The receiver returns an abort request when the host takes the bus from an early transmission. It hands each good byte to the consumer with a one-cycle valid strobe, and it reports a bad frame with a one-cycle error strobe.

Top module: `ps2_dev_rx`

## Requirements
- R1: While reset is asserted and after reset, `ps2_clk_oe`, `ps2_data_oe`, `rx_valid`, `rx_error` and `tx_abort` are 0 and `rx_data` is 0.
- R2: Reception starts only under three conditions: the synchronised CLK has been low, and not caused by the own transmitter, for INHIBIT_CYC consecutive cycles; it then reads high; and DATA reads low at that moment. A shorter low period is ignored and produces no clock pulse.
- R3: Once started, the block makes exactly 11 clock pulses. Each pulse has a released phase of HALF_CYC cycles followed by a driven-low phase of HALF_CYC cycles. The first released phase begins in the cycle after detection.
- R4: DATA is sampled in the last cycle of each released phase. The first ten samples are, in order, the start bit, data bits 0 to 7 (LSB first) and parity. The eleventh sample is the stop bit. `rx_data` shows the 8 data bits when the frame ends.
- R5: Parity is odd. The 8 data bits and the parity bit together must hold an odd number of ones.
- R6: If parity is correct and the stop sample is 1, `ps2_data_oe` rises in the same cycle as the 11th driven-low phase and falls with it. Otherwise `ps2_data_oe` stays 0 for that frame.
- R7: When the 11th low phase ends, a good frame gives one cycle of `rx_valid` and a bad frame gives one cycle of `rx_error`. The two are never high together.
- R8: The host may pull CLK low in a released phase, at least SETTLE_CYC cycles into it. The block then drops the frame, with no strobe and no further pulses, and returns to idle.
- R9: `tx_abort` is high in the cycle after an edge at which three things hold: `tx_busy` is 1, `tx_past_tenth` is 0, and the synchronised CLK is low with no pull from the own transmitter. Once `tx_past_tenth` is 1, no abort is raised.
- R10: A CLK low counts as host inhibit only when `tx_clk_oe` has been 0 in the current cycle and in the MASK_CYC cycles before it.
- R11: No reception starts while `tx_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_in | input | 1 | CLK line level as seen at the pad |
| ps2_data_in | input | 1 | DATA line level as seen at the pad |
| tx_busy | input | 1 | Own transmit path is sending a frame |
| tx_past_tenth | input | 1 | Own transmit path has passed its tenth clock |
| tx_clk_oe | input | 1 | Own transmit path is pulling CLK low |
| ps2_clk_oe | output | 1 | Pull CLK low |
| ps2_data_oe | output | 1 | Pull DATA low |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for a good, acknowledged byte |
| rx_error | output | 1 | One-cycle strobe for a parity or stop failure |
| tx_abort | output | 1 | Request to the transmit path to give up the bus |

## Verification
Two functions can act in the same cycle. The first is the transmit-abort request. The second is the inhibit timer, which counts toward a new reception. When the host pulls CLK during an early transmission, the first cycle of that low raises `tx_abort` and also starts the inhibit count. The bench provokes this by raising `tx_busy` with `tx_past_tenth` low. It pulls CLK from the host side, drops `tx_busy` partway through the inhibit, and then releases CLK with DATA low. A behavioural model, driven by cycle counts from the observed line history, predicts `tx_abort`, the pulse train and the final strobe cycle by cycle. The same scenario is repeated with `tx_past_tenth` high, where neither an abort nor a start may appear.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REL  = 2'd1,
    PH_DRV  = 2'd2
  } phase_t;

  // Odd parity over byte plus parity bit, and stop must read high.
  function automatic logic frame_ok(input logic [7:0] byte_v,
                                    input logic       par_v,
                                    input logic       stop_v);
    return stop_v & (^{byte_v, par_v});
  endfunction

endpackage

// File: rtl/ps2r_sync.sv
module ps2r_sync #(
  parameter int              WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ps2r_inhibit.sv
module ps2r_inhibit #(
  parameter int INHIBIT_CYC = 5000,
  parameter int MASK_CYC    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_s,
  input  logic tx_clk_oe,
  input  logic tx_busy,
  input  logic tx_past_tenth,
  input  logic hold,
  output logic foreign_low,
  output logic inh_done,
  output logic tx_abort
);
  localparam int CW = $clog2(INHIBIT_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(INHIBIT_CYC);

  logic [MASK_CYC-1:0] own_hist;
  logic [CW-1:0]       cnt;
  logic                own_hold;

  generate
    if (MASK_CYC == 1) begin : g_mask1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_hist <= '0;
        else        own_hist <= tx_clk_oe;
      end
    end else begin : g_maskn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_hist <= '0;
        else        own_hist <= {own_hist[MASK_CYC-2:0], tx_clk_oe};
      end
    end
  endgenerate

  assign own_hold    = tx_clk_oe | (|own_hist);
  assign foreign_low = ~clk_s & ~own_hold;
  assign inh_done    = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      tx_abort <= 1'b0;
    end else begin
      tx_abort <= tx_busy & ~tx_past_tenth & foreign_low;
      if (hold)                            cnt <= '0;
      else if (foreign_low && !inh_done)   cnt <= cnt + CW'(1);
      else if (!foreign_low)               cnt <= '0;
    end
  end

  p_abort_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> $past(tx_busy && !tx_past_tenth));

  p_masked_no_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && own_hold) |=> (cnt == '0));

endmodule

// File: rtl/ps2r_framer.sv
module ps2r_framer
  import ps2r_pkg::*;
#(
  parameter int HALF_CYC   = 1000,
  parameter int SETTLE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_s,
  input  logic       data_s,
  input  logic       inh_done,
  input  logic       tx_busy,
  output logic       busy,
  output logic       clk_oe,
  output logic       data_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_error
);
  localparam int NSAMP = 11;
  localparam int TW    = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam int BW    = $clog2(NSAMP + 1);
  localparam logic [TW-1:0] T_LAST   = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC);
  localparam logic [BW-1:0] STOP_IDX = BW'(NSAMP - 1);

  phase_t          st;
  logic [TW-1:0]   tmr;
  logic [BW-1:0]   bitn;
  logic [NSAMP-2:0] sh;
  logic            ack_q;

  logic start_evt, phase_end, host_pull, sample_evt, ack_ok, par_q;

  assign busy       = (st != PH_IDLE);
  assign phase_end  = (tmr == T_LAST);
  assign start_evt  = (st == PH_IDLE) & clk_s & inh_done & ~data_s & ~tx_busy;
  assign host_pull  = (st == PH_REL) & (tmr >= T_SETTLE) & ~clk_s;
  assign sample_evt = (st == PH_REL) & ~host_pull & phase_end;
  assign par_q      = sh[NSAMP-2];
  assign ack_ok     = frame_ok(sh[8:1], par_q, data_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      tmr      <= '0;
      bitn     <= '0;
      sh       <= '0;
      ack_q    <= 1'b0;
      clk_oe   <= 1'b0;
      data_oe  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
      unique case (st)
        PH_IDLE: begin
          if (start_evt) begin
            st   <= PH_REL;
            tmr  <= '0;
            bitn <= '0;
          end
        end
        PH_REL: begin
          if (host_pull) begin
            st <= PH_IDLE;
          end else if (sample_evt) begin
            if (bitn != STOP_IDX) begin
              sh[bitn] <= data_s;
            end else begin
              data_oe <= ack_ok;
              ack_q   <= ack_ok;
            end
            st     <= PH_DRV;
            tmr    <= '0;
            clk_oe <= 1'b1;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        PH_DRV: begin
          if (phase_end) begin
            clk_oe <= 1'b0;
            tmr    <= '0;
            if (bitn == STOP_IDX) begin
              st       <= PH_IDLE;
              data_oe  <= 1'b0;
              rx_data  <= sh[8:1];
              rx_valid <= ack_q;
              rx_error <= ~ack_q;
            end else begin
              bitn <= bitn + BW'(1);
              st   <= PH_REL;
            end
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  p_start_needs_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(inh_done));

  p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!tx_busy));

  p_ack_only_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> clk_oe);

  p_valid_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (^{rx_data, par_q}));

  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_error));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_discard_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_pull |=> (!clk_oe && !rx_valid && !rx_error && !busy));

endmodule

// File: rtl/ps2_dev_rx.sv
module ps2_dev_rx #(
  parameter int INHIBIT_CYC = 5000,
  parameter int HALF_CYC    = 1000,
  parameter int SETTLE_CYC  = 3,
  parameter int MASK_CYC    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       ps2_data_in,
  input  logic       tx_busy,
  input  logic       tx_past_tenth,
  input  logic       tx_clk_oe,
  output logic       ps2_clk_oe,
  output logic       ps2_data_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_error,
  output logic       tx_abort
);
  logic [1:0] line_s;
  logic       clk_s, data_s;
  logic       foreign_low, inh_done, rx_busy;

  ps2r_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ps2_clk_in, ps2_data_in}),
    .q    (line_s)
  );

  assign clk_s  = line_s[1];
  assign data_s = line_s[0];

  ps2r_inhibit #(.INHIBIT_CYC(INHIBIT_CYC), .MASK_CYC(MASK_CYC)) u_inh (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_s        (clk_s),
    .tx_clk_oe    (tx_clk_oe),
    .tx_busy      (tx_busy),
    .tx_past_tenth(tx_past_tenth),
    .hold         (rx_busy),
    .foreign_low  (foreign_low),
    .inh_done     (inh_done),
    .tx_abort     (tx_abort)
  );

  ps2r_framer #(.HALF_CYC(HALF_CYC), .SETTLE_CYC(SETTLE_CYC)) u_frm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_s   (clk_s),
    .data_s  (data_s),
    .inh_done(inh_done),
    .tx_busy (tx_busy),
    .busy    (rx_busy),
    .clk_oe  (ps2_clk_oe),
    .data_oe (ps2_data_oe),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .rx_error(rx_error)
  );

  p_abort_needs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> $past(foreign_low));

endmodule

// File: tb/sim_ps2_dev_rx.sv
module sim_ps2_dev_rx;
  localparam int TCLK = 10;
  localparam int INH  = 40;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_clk_low = 1'b0, host_data_low = 1'b0;
  logic tx_busy = 1'b0, tx_past_tenth = 1'b0, tx_clk_oe = 1'b0;
  logic ps2_clk_oe, ps2_data_oe, rx_valid, rx_error, tx_abort;
  logic [7:0] rx_data;

  wire line_clk  = ~(ps2_clk_oe | host_clk_low | tx_clk_oe);
  wire line_data = ~(ps2_data_oe | host_data_low);

  always #(TCLK/2) clk = ~clk;

  ps2_dev_rx #(.INHIBIT_CYC(INH), .HALF_CYC(HALF), .SETTLE_CYC(3), .MASK_CYC(3)) u0 (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(line_clk), .ps2_data_in(line_data),
    .tx_busy(tx_busy), .tx_past_tenth(tx_past_tenth), .tx_clk_oe(tx_clk_oe),
    .ps2_clk_oe(ps2_clk_oe), .ps2_data_oe(ps2_data_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_error(rx_error), .tx_abort(tx_abort)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: elapsed-cycle arithmetic over the observed line history
  int m_inh = 0, m_fk = -1, p, q;
  logic c1 = 1, c2 = 1, d1 = 1, d2 = 1, t1 = 0, t2 = 0, t3 = 0;
  logic cs, ds, fl, msk, m_ok = 0;
  logic [10:0] mb = '0;
  logic e_clk = 0, e_dat = 0, e_val = 0, e_err = 0, e_abt = 0;
  logic [7:0] e_byte = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_inh = 0; m_fk = -1; c1 = 1; c2 = 1; d1 = 1; d2 = 1; t1 = 0; t2 = 0; t3 = 0;
      e_clk = 0; e_dat = 0; e_val = 0; e_err = 0; e_abt = 0; e_byte = '0;
    end else begin
      cs = c2; ds = d2;
      msk = tx_clk_oe | t1 | t2 | t3;
      fl = !cs && !msk;
      e_abt = tx_busy && !tx_past_tenth && fl;
      e_val = 0; e_err = 0;
      if (m_fk < 0) begin
        if (fl) begin
          if (m_inh < INH) m_inh++;
        end else if (cs && m_inh == INH && !ds && !tx_busy) begin
          m_fk = 0; m_inh = 0;
        end else m_inh = 0;
      end else begin
        p = m_fk % HALF; q = m_fk / HALF;
        if (q % 2 == 0 && p >= 3 && !cs) begin
          m_fk = -1; m_inh = 0;
        end else begin
          if (q % 2 == 0 && p == HALF - 1) begin
            mb[q/2] = ds;
            if (q/2 == 10) m_ok = ds && (^mb[9:1]);
          end
          m_fk++;
          if (m_fk == 22*HALF) begin
            e_byte = mb[8:1]; e_val = m_ok; e_err = !m_ok; m_fk = -1; m_inh = 0;
          end
        end
      end
      e_clk = (m_fk > 0) && ((m_fk / HALF) % 2 == 1);
      e_dat = e_clk && (m_fk >= 21*HALF) && m_ok;
      c2 = c1; c1 = line_clk; d2 = d1; d1 = line_data;
      t3 = t2; t2 = t1; t1 = tx_clk_oe;
    end
  end

  int n_val = 0, n_err = 0, n_fall = 0, n_ack = 0, n_abort = 0;
  logic prev_oe = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ps2_clk_oe == e_clk, "R3 clk_oe", ps2_clk_oe, e_clk);
      chk(ps2_data_oe == e_dat, "R6 data_oe", ps2_data_oe, e_dat);
      chk(rx_valid == e_val, "R7 rx_valid", rx_valid, e_val);
      chk(rx_error == e_err, "R7 rx_error", rx_error, e_err);
      chk(rx_data == e_byte, "R4 rx_data", rx_data, e_byte);
      chk(tx_abort == e_abt, "R9 tx_abort", tx_abort, e_abt);
      if (rx_valid) n_val++;
      if (rx_error) n_err++;
      if (ps2_data_oe) n_ack++;
      if (tx_abort) n_abort++;
      if (ps2_clk_oe && !prev_oe) n_fall++;
      prev_oe = ps2_clk_oe;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_drv();
    while (!ps2_clk_oe) @(negedge clk);
  endtask
  task automatic wait_rel();
    while (ps2_clk_oe) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit stop_hi,
                            input bit drop_tx);
    logic [9:0] bv;
    bv = {stop_hi, (~^b) ^ bad_par, b};
    host_clk_low = 1;
    for (int i = 0; i < INH + 10; i++) begin
      @(negedge clk);
      if (drop_tx && i == 6) tx_busy = 0;
    end
    host_data_low = 1;
    @(negedge clk);
    host_clk_low = 0;
    for (int j = 0; j < 10; j++) begin
      wait_drv();
      host_data_low = !bv[j];
      wait_rel();
    end
    wait_drv();
    wait_rel();
    host_data_low = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic good_frame(input logic [7:0] b);
    int v0, f0, a0;
    v0 = n_val; f0 = n_fall; a0 = n_ack;
    send_frame(b, 0, 1, 0);
    chk(n_fall - f0 == 11, "R3 pulse count", n_fall - f0, 11);
    chk(n_val - v0 == 1, "R7 valid count", n_val - v0, 1);
    chk(rx_data == b, "R4 byte LSB first", rx_data, b);
    chk(n_ack - a0 == HALF, "R6 ack length", n_ack - a0, HALF);
  endtask

  initial begin
    int v0, e0, f0, a0, ab0;
    repeat (3) @(negedge clk);
    chk(ps2_clk_oe == 0 && ps2_data_oe == 0, "R1 reset line enables", ps2_clk_oe, 0);
    chk(rx_valid == 0 && rx_error == 0 && tx_abort == 0, "R1 reset strobes", rx_valid, 0);
    chk(rx_data == 0, "R1 reset data", rx_data, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R2: short inhibit ignored
    f0 = n_fall;
    host_clk_low = 1; repeat (20) @(negedge clk);
    host_data_low = 1; @(negedge clk); host_clk_low = 0;
    repeat (60) @(negedge clk); host_data_low = 0; repeat (5) @(negedge clk);
    chk(n_fall == f0, "R2 short inhibit ignored", n_fall - f0, 0);

    // R3 R4 R6 R7: clean frames
    good_frame(8'hA5);
    good_frame(8'h00);
    good_frame(8'hFF);
    good_frame(8'h3C);

    // R5: parity failure
    v0 = n_val; e0 = n_err; a0 = n_ack;
    send_frame(8'h5A, 1, 1, 0);
    chk(n_err - e0 == 1 && n_val == v0, "R5 bad parity flagged", n_err - e0, 1);
    chk(n_ack == a0, "R6 no ack on bad parity", n_ack - a0, 0);

    // R6: missing stop bit
    e0 = n_err; a0 = n_ack;
    send_frame(8'h81, 0, 0, 0);
    chk(n_err - e0 == 1, "R6 missing stop flagged", n_err - e0, 1);
    chk(n_ack == a0, "R6 no ack without stop", n_ack - a0, 0);

    // R8: host pulls CLK mid-frame
    v0 = n_val; e0 = n_err; f0 = n_fall;
    host_clk_low = 1; repeat (INH + 10) @(negedge clk);
    host_data_low = 1; @(negedge clk); host_clk_low = 0;
    wait_drv(); wait_rel(); wait_drv(); wait_rel();
    repeat (3) @(negedge clk);
    host_clk_low = 1; repeat (15) @(negedge clk);
    host_clk_low = 0; host_data_low = 0;
    repeat (60) @(negedge clk);
    chk(n_fall - f0 == 2, "R8 pulses stop after discard", n_fall - f0, 2);
    chk(n_val == v0 && n_err == e0, "R8 no strobe after discard", n_val - v0, 0);

    // R9: arbitration, abort then receive
    ab0 = n_abort; v0 = n_val;
    tx_busy = 1; tx_past_tenth = 0;
    send_frame(8'h96, 0, 1, 1);
    chk(n_abort > ab0, "R9 abort raised", n_abort - ab0, 1);
    chk(n_val - v0 == 1 && rx_data == 8'h96, "R9 receive after abort", rx_data, 8'h96);

    // R9: no abort once past the tenth clock
    ab0 = n_abort;
    tx_busy = 1; tx_past_tenth = 1;
    host_clk_low = 1; repeat (10) @(negedge clk); host_clk_low = 0;
    repeat (10) @(negedge clk);
    chk(n_abort == ab0, "R9 no abort past tenth", n_abort - ab0, 0);

    // R11: full inhibit while busy does not start reception
    f0 = n_fall;
    host_clk_low = 1; repeat (INH + 10) @(negedge clk);
    host_data_low = 1; @(negedge clk); host_clk_low = 0;
    repeat (60) @(negedge clk);
    host_data_low = 0; tx_busy = 0; tx_past_tenth = 0;
    repeat (10) @(negedge clk);
    chk(n_fall == f0, "R11 no start while busy", n_fall - f0, 0);

    // R10: own transmitter CLK low is not host inhibit
    f0 = n_fall;
    tx_clk_oe = 1; repeat (INH + 20) @(negedge clk);
    host_data_low = 1; @(negedge clk); tx_clk_oe = 0;
    repeat (60) @(negedge clk);
    host_data_low = 0; repeat (5) @(negedge clk);
    chk(n_fall == f0, "R10 own low masked", n_fall - f0, 0);

    good_frame(8'h69);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule